// File: doc/BRIEF.md
# Multi-Clock Edge-Triggered Register

This block is a single stored bit that can be loaded from any of several independent source clocks. Each source clock lane has its own data input. The whole block runs on one fast sampling clock. On every sampling edge it compares each source clock with the level it had at the previous sample, and a 0 to 1 change counts as a load event for that lane.

When one or more lanes have a load event, the stored bit takes the data those lanes carried at the previous sample. Using the previous sample settles the race between a source clock edge and a data change that land in the same sample. When no lane has a load event, the bit holds its value.

A second output pulses for one sample in every cycle in which the bit was reloaded. The lane count is a parameter. With one lane, the block acts as an ordinary D flip-flop clocked by that lane.

Top module: `multi_clk_reg`

## Requirements
- R1: Synchronous active-high `rst_i` clears `q_o`, `edge_seen_o` and the stored clock and data history to 0. A lane that is high at the first sample after reset therefore counts as rising, and it loads 0.
- R2: Lane i rises when `src_clk_i[i]` was 0 at the previous sampling edge and is 1 at this one. On that sampling edge, `q_o` is reloaded, and the new value is visible right after that edge.
- R3: The value loaded is the lane's `src_dat_i` bit as sampled at the previous sampling edge. A data change that arrives in the same sample as the rise is not captured.
- R4: Falling transitions and steady levels on every lane leave `q_o` unchanged.
- R5: When several lanes rise in the same sample, the new `q_o` is the OR of the previous-sample data bits of the rising lanes.
- R6: `edge_seen_o` is 1 in exactly those cycles that follow a sampling edge at which `q_o` was reloaded. Otherwise it is 0.
- R7: With `NUM_LANES` = 1, the block behaves as a D flip-flop clocked by the rising edge of lane 0, using previous-sample data.
- R8: The data bit of a lane that does not rise has no effect on the loaded value, even when other lanes rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock; all state changes on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| src_clk_i | input | NUM_LANES | Source clock of each lane; bit i is lane i |
| src_dat_i | input | NUM_LANES | Data of each lane; bit i pairs with `src_clk_i[i]` |
| q_o | output | 1 | Stored bit |
| edge_seen_o | output | 1 | High for one cycle after a reload |

## Verification
The hardest situation to reach is a rising edge that arrives in the same sample as a data change on the same lane. Only this case shows whether the block captures the previous-sample data or the current data. The bench reaches it by changing `src_dat_i` and `src_clk_i` in the same drive step, after holding the opposite data for a full sample beforehand.

The bench also holds lanes high through a reset release, so that the reset-cleared history produces a load. A one-lane copy of the block runs alongside the three-lane one on the same lane-0 stimulus, and its output is compared with a flip-flop model.

// File: rtl/mcr_pkg.sv
`timescale 1ns/1ps
package mcr_pkg;

    // Action taken by the storage bit in one sample
    typedef enum logic {
        ACT_HOLD = 1'b0,
        ACT_LOAD = 1'b1
    } mcr_act_e;

endpackage

// File: rtl/mcr_rise_detect.sv
`timescale 1ns/1ps
module mcr_rise_detect #(
    parameter int NUM_LANES = 3
) (
    input  logic [NUM_LANES-1:0] cur_i,
    input  logic [NUM_LANES-1:0] prev_i,
    output logic [NUM_LANES-1:0] rise_o,
    output logic                 any_rise_o
);

    // One comparator per lane: low at last sample, high now
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        assign rise_o[g] = cur_i[g] & ~prev_i[g];
    end

    assign any_rise_o = |rise_o;

endmodule

// File: rtl/mcr_data_merge.sv
`timescale 1ns/1ps
module mcr_data_merge #(
    parameter int NUM_LANES = 3
) (
    input  logic [NUM_LANES-1:0] rise_i,
    input  logic [NUM_LANES-1:0] dat_prev_i,
    output logic                 merged_o
);

    logic [NUM_LANES-1:0] masked;

    // Lanes without a rise are masked out before the OR reduction
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_mask
        assign masked[g] = rise_i[g] & dat_prev_i[g];
    end

    assign merged_o = |masked;

endmodule

// File: rtl/multi_clk_reg.sv
`timescale 1ns/1ps
module multi_clk_reg
    import mcr_pkg::*;
#(
    parameter int NUM_LANES = 3
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic [NUM_LANES-1:0] src_clk_i,
    input  logic [NUM_LANES-1:0] src_dat_i,
    output logic                 q_o,
    output logic                 edge_seen_o
);

    localparam int LW = NUM_LANES;

    typedef struct packed {
        logic [LW-1:0] clk_hist;
        logic [LW-1:0] dat_hist;
        logic          bit_val;
        logic          loaded;
    } mcr_state_t;

    mcr_state_t st_d, st_q;
    logic [LW-1:0] rise;
    logic          any_rise;
    logic          merged;
    mcr_act_e      act;

    mcr_rise_detect #(.NUM_LANES(LW)) rise_i (
        .cur_i     (src_clk_i),
        .prev_i    (st_q.clk_hist),
        .rise_o    (rise),
        .any_rise_o(any_rise)
    );

    mcr_data_merge #(.NUM_LANES(LW)) merge_i (
        .rise_i    (rise),
        .dat_prev_i(st_q.dat_hist),
        .merged_o  (merged)
    );

    always_comb begin
        act = any_rise ? ACT_LOAD : ACT_HOLD;
        st_d          = st_q;
        st_d.clk_hist = src_clk_i;
        st_d.dat_hist = src_dat_i;
        st_d.loaded   = (act == ACT_LOAD);
        if (act == ACT_LOAD) begin
            st_d.bit_val = merged;
        end
        if (rst_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        st_q <= st_d;
    end

    assign q_o         = st_q.bit_val;
    assign edge_seen_o = st_q.loaded;

    AST_RESET_CLEAR: assert property (@(posedge clk_i)
        rst_i |=> (!q_o && !edge_seen_o)); // R1

    AST_LOAD_FLAG: assert property (@(posedge clk_i) disable iff (rst_i)
        (|(src_clk_i & ~st_q.clk_hist)) |=> edge_seen_o); // R6

    AST_HOLD_LEVEL: assert property (@(posedge clk_i) disable iff (rst_i)
        !(|(src_clk_i & ~st_q.clk_hist)) |=> (!edge_seen_o && $stable(q_o))); // R4

    AST_OLD_DATA: assert property (@(posedge clk_i) disable iff (rst_i)
        (|(src_clk_i & ~st_q.clk_hist & st_q.dat_hist)) |=> q_o); // R3

    AST_MASK_IDLE: assert property (@(posedge clk_i) disable iff (rst_i)
        ((|(src_clk_i & ~st_q.clk_hist)) && !(|(src_clk_i & ~st_q.clk_hist & st_q.dat_hist)))
        |=> !q_o); // R8

endmodule

// File: tb/multi_clk_reg_tb_top.sv
`timescale 1ns/1ps
module multi_clk_reg_tb_top;

    localparam int N = 3;

    logic         clk = 1'b0;
    logic         rst;
    logic [N-1:0] sclk;
    logic [N-1:0] sdat;
    logic         q3, e3, q1, e1;

    always #2.5 clk = ~clk;

    multi_clk_reg #(.NUM_LANES(N)) dut_i (
        .clk_i(clk), .rst_i(rst), .src_clk_i(sclk), .src_dat_i(sdat),
        .q_o(q3), .edge_seen_o(e3)
    );

    multi_clk_reg #(.NUM_LANES(1)) dff_i (
        .clk_i(clk), .rst_i(rst), .src_clk_i(sclk[0]), .src_dat_i(sdat[0]),
        .q_o(q1), .edge_seen_o(e1)
    );

    typedef struct {
        logic  q3, e3, q1, e1;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int errors = 0;
    bit drv_done = 0;

    // Reference model state, built from the requirements
    logic [N-1:0] m_clk = '0, m_dat = '0;
    logic         m_q3 = 0, m_q1 = 0;

    task automatic check(input string req, input logic act, input logic expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, expv);
        end
    endtask

    task automatic step(input logic r, input logic [N-1:0] c,
                        input logic [N-1:0] d, input string tag);
        exp_t it;
        logic [N-1:0] rz;
        logic rz1;
        @(negedge clk);
        rst = r; sclk = c; sdat = d;
        rz  = c & ~m_clk;
        rz1 = c[0] & ~m_clk[0];
        if (r) begin
            m_q3 = 0; m_q1 = 0; it.e3 = 0; it.e1 = 0;
            m_clk = '0; m_dat = '0;
        end else begin
            it.e3 = |rz;
            it.e1 = rz1;
            if (|rz) m_q3 = |(rz & m_dat);
            if (rz1) m_q1 = m_dat[0];
            m_clk = c; m_dat = d;
        end
        it.q3 = m_q3; it.q1 = m_q1; it.tag = tag;
        exp_q.push_back(it);
    endtask

    // Monitor: samples shortly after each sampling edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t it;
                it = exp_q.pop_front();
                check({it.tag, " q"}, q3, it.q3);
                check({it.tag, " R6 edge_seen"}, e3, it.e3);
                check("R7 q single-lane", q1, it.q1);
                check("R7 R6 edge_seen single-lane", e1, it.e1);
            end
        end
    end

    initial begin
        logic [7:0] lf;
        rst = 1; sclk = '1; sdat = '0;
        step(1, 3'b111, 3'b111, "R1 reset");
        step(1, 3'b111, 3'b000, "R1 reset");
        step(0, 3'b000, 3'b000, "R1 idle");
        // R2: single rise on lane 0
        step(0, 3'b000, 3'b001, "R2 setup");
        step(0, 3'b001, 3'b001, "R2 load");
        // R4: steady high and falling keep q
        step(0, 3'b001, 3'b000, "R4 steady");
        step(0, 3'b000, 3'b000, "R4 fall");
        step(0, 3'b000, 3'b000, "R4 idle");
        // R3: data changes in the same sample as the rise
        step(0, 3'b001, 3'b001, "R3 race low");
        step(0, 3'b000, 3'b001, "R3 fall");
        step(0, 3'b001, 3'b000, "R3 race high");
        // R5: simultaneous rises OR their old data
        step(0, 3'b000, 3'b010, "R5 setup");
        step(0, 3'b110, 3'b000, "R5 load or");
        step(0, 3'b000, 3'b000, "R5 clear");
        step(0, 3'b110, 3'b110, "R5 load zero");
        step(0, 3'b000, 3'b000, "R5 idle");
        // R8: non-rising lane data is ignored
        step(0, 3'b000, 3'b100, "R8 setup");
        step(0, 3'b011, 3'b100, "R8 masked");
        step(0, 3'b111, 3'b011, "R8 lane2 rise");
        step(0, 3'b000, 3'b000, "R8 idle");
        // R1: reset while lanes high, release with lanes still high
        step(0, 3'b000, 3'b111, "R1 preset");
        step(1, 3'b111, 3'b111, "R1 mid reset");
        step(0, 3'b111, 3'b111, "R1 release");
        step(0, 3'b111, 3'b111, "R1 hold");
        // R2 mixed patterns from an LFSR
        lf = 8'hA5;
        for (int i = 0; i < 60; i++) begin
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            step(0, lf[2:0], lf[6:4], "R2 mixed");
        end
        repeat (3) @(negedge clk);
        drv_done = 1;
    end

    initial begin
        fork
            begin
                wait (drv_done && exp_q.size() == 0);
            end
            begin
                repeat (5000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule